// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Per-Channel Output Modes

This block is a bank of pulse-width modulated outputs that share one 16-bit up-counting timebase. The timer runs from 0 to a programmable period and then returns to 0, so one PWM cycle lasts period+1 clocks. Each channel compares the running count against its own match value. A 2-bit mode field per channel chooses the output behaviour: low before the match, high before the match, fixed low, or fixed high. A per-channel enable bit gates the result, and a disabled channel rests at 0.

Software programs the bank through a flat word-addressed register port. A write is a single cycle with `wr_en` high. Reads are combinational from `addr`. Period and match writes go into staging registers. The live copies used by the comparators are reloaded only when the counter wraps, so a waveform never changes shape partway through a cycle. Mode and enable writes act at once. All channel outputs are registered.

Top module: `pwm_mode_bank`

## Requirements
- R1: The counter starts at 0, adds one on every clock, and returns to 0 on the clock after it equals the live period. A PWM cycle is therefore period+1 clocks long.
- R2: Mode code 00 makes a channel output 0 while count < live match value, and 1 otherwise.
- R3: Mode code 01 makes a channel output 1 while count < live match value, and 0 otherwise.
- R4: Mode code 10 holds an enabled channel at 0. Mode code 11 holds an enabled channel at 1. Neither depends on the count.
- R5: Register address 2 holds the enables, with bit n for channel n. A channel whose enable bit is 0 outputs 0 in every mode.
- R6: In both PWM modes, a match value of 0 gives the "otherwise" level for the whole cycle. A match value above the period gives the "count < match" level for the whole cycle.
- R7: Period and match writes first reach the staging registers. They reach the comparators only at the clock on which the counter wraps. A write that lands on a wrap clock waits for the next wrap.
- R8: Outputs are registered. Each output reflects the count, mode and enable of the previous clock.
- R9: After a synchronous active-low reset, all of the following are 0: the period, every match value, every mode field, every enable bit, the counter and every output.
- R10: The register map is as follows. Address 0 is the period (bits [15:0]). Address 1 holds the modes, with channel n in bits [2n+1:2n]. Address 2 holds the enables. Address 3+n is the match value of channel n. Unused bits and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W (4) | Register word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| pwm_out | output | NUM_CH (9) | Registered channel outputs |

## Verification
Two things can happen in the same clock: a register write and the counter wrap that reloads the live period and match copies. When both occur, the wrap must capture the value held before the write, and the new value must wait a full cycle. The bench provokes this case in two ways. It writes at arbitrary points in a 10-clock cycle, and it also sets the period to 0 so that every clock is a wrap. A behavioural model predicts the result of every clock and is compared against all nine outputs on each clock.

// File: rtl/pwm_pkg.sv
// Shared definitions for the PWM bank: mode codes and register word addresses.
// Assumes the word addresses below are decoded by pwm_regs and nowhere else.
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_LOW_FIRST  = 2'b00,
        MODE_HIGH_FIRST = 2'b01,
        MODE_FORCE_LO   = 2'b10,
        MODE_FORCE_HI   = 2'b11
    } pwm_mode_e;

    localparam int ADDR_PERIOD = 0;
    localparam int ADDR_MODES  = 1;
    localparam int ADDR_ENABLE = 2;
    localparam int ADDR_MATCH0 = 3;

endpackage

// File: rtl/pwm_regs.sv
// Register file for the PWM bank. It holds the staging copies of period and match
// written by software, the live copies that reload on the counter wrap, and the
// mode and enable fields, which act at once.
// Assumes DATA_W covers CNT_W, 2*NUM_CH and NUM_CH bits.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic                    wrap,
    output logic [CNT_W-1:0]        period_act,
    output logic [NUM_CH*CNT_W-1:0] match_act,
    output logic [2*NUM_CH-1:0]     modes,
    output logic [NUM_CH-1:0]       enables
);

    localparam int MODE_W = 2 * NUM_CH;

    logic [CNT_W-1:0] period_stg;
    logic [CNT_W-1:0] match_stg [NUM_CH];

    // Period staging register and its live copy, reloaded only on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_stg <= '0;
            period_act <= '0;
        end else begin
            if (wrap)
                period_act <= period_stg;
            if (wr_en && addr == ADDR_W'(ADDR_PERIOD))
                period_stg <= wdata[CNT_W-1:0];
        end
    end

    // Match staging registers and live copies, one pair per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                match_stg[i]                <= '0;
                match_act[i*CNT_W +: CNT_W] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wrap)
                    match_act[i*CNT_W +: CNT_W] <= match_stg[i];
                if (wr_en && addr == ADDR_W'(ADDR_MATCH0 + i))
                    match_stg[i] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Mode and enable fields, applied without waiting for a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modes   <= '0;
            enables <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_MODES))
                modes <= wdata[MODE_W-1:0];
            if (addr == ADDR_W'(ADDR_ENABLE))
                enables <= wdata[NUM_CH-1:0];
        end
    end

    // Read mux over the software-visible (staging) values; unmapped reads give 0.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_PERIOD))
            rdata = DATA_W'(period_stg);
        if (addr == ADDR_W'(ADDR_MODES))
            rdata = DATA_W'(modes);
        if (addr == ADDR_W'(ADDR_ENABLE))
            rdata = DATA_W'(enables);
        for (int i = 0; i < NUM_CH; i++)
            if (addr == ADDR_W'(ADDR_MATCH0 + i))
                rdata = DATA_W'(match_stg[i]);
    end

    AST_PERIOD_HOLDS_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(period_act)) else $error("live period moved off wrap"); // R7

    AST_MATCH_HOLDS_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(match_act)) else $error("live match moved off wrap"); // R7

endmodule

// File: rtl/pwm_counter.sv
// Up-counting timebase. It counts 0..period_act and flags the wrap clock.
// Assumes period_act changes only on the wrap flagged here.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    // Wrap when the count has reached (or somehow passed) the live period.
    always_comb wrap = (cnt >= period_act);

    // Advance the count, or return to zero on the wrap clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= period_act) else $error("count above period"); // R1

    AST_WRAP_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == period_act) |=> (cnt == '0)) else $error("no wrap to zero"); // R1

    AST_COUNT_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < period_act) |=> (cnt == $past(cnt) + CNT_W'(1))) else $error("bad step"); // R1

endmodule

// File: rtl/pwm_channel.sv
// One PWM channel. It compares the count with its live match value, applies the
// mode and the enable gate, and registers the result.
// Assumes the mode and enable inputs are already register outputs.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] match_val,
    input  logic [1:0]       mode,
    input  logic             enable,
    output logic             pwm
);

    logic before_match;
    logic next_level;

    // Compare: true while the count is still below the match value.
    always_comb before_match = (cnt < match_val);

    // Decode the mode into the level for the next clock.
    always_comb begin
        case (pwm_mode_e'(mode))
            MODE_LOW_FIRST:  next_level = !before_match;
            MODE_HIGH_FIRST: next_level = before_match;
            MODE_FORCE_LO:   next_level = 1'b0;
            default:         next_level = 1'b1;
        endcase
    end

    // Output register with the enable gate; a disabled channel rests at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm <= 1'b0;
        else
            pwm <= enable & next_level;
    end

    AST_DISABLED_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm) else $error("disabled channel high"); // R5

    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'b10) |=> !pwm) else $error("forced-low channel high"); // R4

    AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'b11) |=> pwm) else $error("forced-high channel low"); // R4

endmodule

// File: rtl/pwm_mode_bank.sv
// Top of the PWM bank: one shared timebase, a register file, and NUM_CH channels.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_mode_bank #(
    parameter int NUM_CH = 9,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(NUM_CH + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CNT_W-1:0]        cnt;
    logic                    wrap;
    logic [CNT_W-1:0]        period_act;
    logic [NUM_CH*CNT_W-1:0] match_act;
    logic [2*NUM_CH-1:0]     modes;
    logic [NUM_CH-1:0]       enables;

    pwm_regs #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wrap(wrap), .period_act(period_act),
        .match_act(match_act), .modes(modes), .enables(enables)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .period_act(period_act), .cnt(cnt), .wrap(wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .match_val(match_act[ch*CNT_W +: CNT_W]),
            .mode(modes[2*ch +: 2]), .enable(enables[ch]),
            .pwm(pwm_out[ch])
        );
    end

endmodule

// File: tb/pwm_mode_bank_test.sv
// Bench for pwm_mode_bank: a behavioural model advances on every posedge and is
// compared against all outputs on every negedge.
module pwm_mode_bank_test;

    localparam int NCH = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    string phase = "R9 reset";

    always #5 clk = ~clk;

    pwm_mode_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    // Behavioural model state
    int m_cnt, m_period, m_period_live;
    int m_match [NCH];
    int m_match_live [NCH];
    logic [17:0] m_mode;
    logic [NCH-1:0] m_en;
    logic [NCH-1:0] exp_out;
    string exp_tag [NCH];
    bit started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_period = 0; m_period_live = 0;
            m_mode = '0; m_en = '0; exp_out = '0;
            for (int c = 0; c < NCH; c++) begin
                m_match[c] = 0; m_match_live[c] = 0; exp_tag[c] = "R9";
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                logic [1:0] md;
                bit below;
                md = m_mode[2*c +: 2];
                below = (m_cnt < m_match_live[c]);
                if (!m_en[c]) begin
                    exp_out[c] = 1'b0; exp_tag[c] = "R5";
                end else if (md == 2'b10) begin
                    exp_out[c] = 1'b0; exp_tag[c] = "R4";
                end else if (md == 2'b11) begin
                    exp_out[c] = 1'b1; exp_tag[c] = "R4";
                end else begin
                    exp_out[c] = (md == 2'b01) ? below : !below;
                    if (m_match_live[c] == 0 || m_match_live[c] > m_period_live)
                        exp_tag[c] = "R6";
                    else
                        exp_tag[c] = (md == 2'b01) ? "R3" : "R2";
                end
            end
            if (m_cnt >= m_period_live) begin
                m_cnt = 0;
                m_period_live = m_period;
                for (int c = 0; c < NCH; c++) m_match_live[c] = m_match[c];
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                if (addr == 0) m_period = int'(wdata[15:0]);
                else if (addr == 1) m_mode = wdata[17:0];
                else if (addr == 2) m_en = wdata[NCH-1:0];
                else if (addr >= 3 && addr < 3 + NCH) m_match[addr-3] = int'(wdata[15:0]);
            end
        end
        started = 1;
    end

    // Per-clock comparison of every channel against the model (R8 timing).
    always @(negedge clk) begin
        if (started) begin
            for (int c = 0; c < NCH; c++) begin
                n_checks++;
                if (pwm_out[c] !== exp_out[c]) begin
                    n_fail++;
                    $display("FAIL %s/%s/R8 ch%0d got %b expected %b at %0t",
                             phase, exp_tag[c], c, pwm_out[c], exp_out[c], $time);
                end
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a == 0) return 32'(m_period);
        if (a == 1) return 32'(m_mode);
        if (a == 2) return 32'(m_en);
        if (a >= 3 && a < 3 + NCH) return 32'(m_match[a-3]);
        return 32'h0;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int a, input string tag);
        @(negedge clk);
        addr = 4'(a);
        #1;
        n_checks++;
        if (rdata !== exp_read(4'(a))) begin
            n_fail++;
            $display("FAIL %s addr %0d got %h expected %h", tag, a, rdata, exp_read(4'(a)));
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: measure clocks between rising edges of channel 1 (mode 01).
    task automatic period_check(input int expected);
        int gap = 0;
        bit prev;
        bit seen = 0;
        bit done = 0;
        @(negedge clk);
        prev = pwm_out[1];
        for (int i = 0; i < 4 * expected + 8 && !done; i++) begin
            @(negedge clk);
            gap++;
            if (pwm_out[1] && !prev) begin
                if (seen) begin
                    n_checks++;
                    if (gap != expected) begin
                        n_fail++;
                        $display("FAIL R1 cycle length got %0d expected %0d", gap, expected);
                    end
                    done = 1;
                end
                seen = 1;
                gap = 0;
            end
            prev = pwm_out[1];
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 no two rising edges got 0 expected %0d", expected);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        run(5);
        for (int a = 0; a < 16; a++) rd_check(a, "R9 reset readback");
        rst_n = 1'b1;

        phase = "R1 R2 R3 R4 setup";
        wr(0, 9);
        wr(3 + 0, 3); wr(3 + 1, 5); wr(3 + 4, 2); wr(3 + 5, 9);
        wr(3 + 6, 0); wr(3 + 7, 12); wr(3 + 8, 9);
        // ch0 00, ch1 01, ch2 10, ch3 11, ch4 00, ch5 01, ch6 00, ch7 01, ch8 00
        wr(1, 32'b00_01_00_01_00_11_10_01_00);
        wr(2, 32'h1EF);                      // all but ch4 enabled
        run(40);
        period_check(10);

        phase = "R7 mid-cycle shadow";
        run(4);
        wr(0, 5); wr(3, 1);
        run(30);
        wr(3 + 1, 2);
        run(20);

        phase = "R5 enable";
        wr(2, 0);
        run(12);
        wr(2, 32'h1FF);
        run(15);

        phase = "R10 readback";
        for (int a = 0; a < 16; a++) rd_check(a, "R10 register map");
        wr(1, 32'hFFFF_FFFF);
        rd_check(1, "R10 mode width");
        wr(2, 32'hFFFF_FFFF);
        rd_check(2, "R10 enable width");
        wr(1, 32'b00_01_00_01_00_11_10_01_00);

        phase = "R7 wrap every clock";
        wr(0, 0);
        run(6);
        wr(3, 1); wr(0, 7);
        run(25);
        phase = "R6 match edges";
        wr(3 + 6, 7); wr(3 + 7, 8); wr(3 + 8, 0);
        run(25);

        phase = "R9 reset again";
        @(negedge clk); rst_n = 1'b0;
        run(3);
        rd_check(0, "R9 period cleared");
        rd_check(3, "R9 match cleared");
        rst_n = 1'b1;
        run(5);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule